// File: doc/BRIEF.md
# Receiver Detect Handshake Sequencer

This block runs the far-end receiver detection handshake for a single serial transmit lane. It runs on the lane's parallel clock. The link layer raises a detect request. The sequencer then holds the transmit driver in electrical idle, which is its tri-state condition, for a guaranteed lead time. After that it raises the detect control toward the analog front end.

The front end has a variable response latency. The sequencer waits for the front end's result, qualified by a valid strobe, and reports the outcome as a one-cycle done pulse carrying a 3-bit status code. After the report it first drops the detect control and then releases electrical idle. It is ready for a new request two cycles after the done pulse.

An optional watchdog ends a wait that never completes and reports "not detected", so a silent front end cannot hang the lane.

Top module: `rxdet_seq`

## Requirements
- R1: A synchronous active-low reset leaves elec_idle_o high, det_ctrl_o low, done_o low and status_o at 3'b000.
- R2: After det_req_i is sampled high in the idle state, elec_idle_o is high from the next cycle on. det_ctrl_o rises exactly LEAD_CYC (default 10) cycles later, and elec_idle_o is high in every cycle in which det_ctrl_o is high.
- R3: Once raised, det_ctrl_o stays high until fe_valid_i is sampled high or the watchdog expires. fe_found_i is only looked at in a cycle where fe_valid_i is high.
- R4: In the cycle after fe_valid_i is sampled high with fe_found_i high, done_o is high for one cycle with status_o = 3'b011, and det_ctrl_o falls in that same cycle.
- R5: If fe_found_i is low when fe_valid_i is sampled, the done pulse carries status_o = 3'b000.
- R6: done_o is never high in two consecutive cycles, and status_o is 3'b000 whenever done_o is low.
- R7: det_req_i is ignored while a sequence is running. A request held high from the done cycle onward is accepted on the third clock edge after the done pulse, so that elec_idle_o rises three cycles after done_o.
- R8: With TMO_EN set, if det_ctrl_o has been high for TMO_CYC (default 4096) cycles with no valid result, the sequence ends with done_o high and status_o = 3'b000. A valid result sampled on the last of those cycles still wins.
- R9: elec_idle_o falls in the cycle after the done pulse, which is one cycle after det_ctrl_o falls, and stays low in idle until the next accepted request.
- R10: fe_valid_i and fe_found_i have no effect outside the detect wait: a valid pulse in idle or during the lead time produces no done pulse and does not shorten the lead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_req_i | input | 1 | Detect request from the link layer |
| fe_valid_i | input | 1 | Front-end result valid strobe |
| fe_found_i | input | 1 | Front-end result: far-end receiver present |
| elec_idle_o | output | 1 | Force transmit driver into electrical idle (tri-state) |
| det_ctrl_o | output | 1 | Detect control to the analog front end |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 3 | Completion code: 3'b011 found, 3'b000 not found |

## Verification
The front end is driven with several result latencies. A zero latency shows that the very first wait cycle is honoured. Short and mid latencies show that the wait scales with the input. A latency of TMO_CYC-1 against one of TMO_CYC tells a valid result on the last wait cycle apart from a watchdog expiry. Both result polarities are used to separate the two status codes.

Other runs inject request and valid pulses during the lead time and the wait, and valid pulses while idle. These show that requests and results outside their window are dropped. A request held high through a done pulse pins down the earliest cycle at which a new request is accepted.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_FORCE   = 3'd1,
      ST_DETECT  = 3'd2,
      ST_REPORT  = 3'd3,
      ST_RELEASE = 3'd4
   } rxdet_state_e;

   localparam int unsigned CODE_W = 3;
   localparam logic [CODE_W-1:0] CODE_FOUND = 3'b011;
   localparam logic [CODE_W-1:0] CODE_NONE  = 3'b000;

endpackage

// File: rtl/rxdet_span_cnt.sv
// Saturating span counter: counts while run_i is high, clears otherwise,
// flags the cycle in which LIMIT cycles of running have been reached.
module rxdet_span_cnt #(
   parameter int unsigned LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic hit_o
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rxdet_span_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/rxdet_fsm.sv
module rxdet_fsm
   import rxdet_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               det_req_i,
   input  logic               fe_valid_i,
   input  logic               fe_found_i,
   input  logic               lead_hit_i,
   input  logic               tmo_hit_i,
   output rxdet_state_e       state_o,
   output logic               elec_idle_o,
   output logic               det_ctrl_o,
   output logic               done_o,
   output logic [CODE_W-1:0]  status_o
);
   rxdet_state_e       state_q;
   logic               eidle_q;
   logic               det_q;
   logic               done_q;
   logic [CODE_W-1:0]  stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         eidle_q <= 1'b1;
         det_q   <= 1'b0;
         done_q  <= 1'b0;
         stat_q  <= CODE_NONE;
      end else begin
         done_q <= 1'b0;
         stat_q <= CODE_NONE;
         case (state_q)
            ST_IDLE: begin
               if (det_req_i) begin
                  state_q <= ST_FORCE;
                  eidle_q <= 1'b1;
               end
            end
            ST_FORCE: begin
               if (lead_hit_i) begin
                  state_q <= ST_DETECT;
                  det_q   <= 1'b1;
               end
            end
            ST_DETECT: begin
               if (fe_valid_i || tmo_hit_i) begin
                  state_q <= ST_REPORT;
                  det_q   <= 1'b0;
                  done_q  <= 1'b1;
                  stat_q  <= (fe_valid_i && fe_found_i) ? CODE_FOUND : CODE_NONE;
               end
            end
            ST_REPORT: begin
               state_q <= ST_RELEASE;
               eidle_q <= 1'b0;
            end
            ST_RELEASE: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign state_o     = state_q;
   assign elec_idle_o = eidle_q;
   assign det_ctrl_o  = det_q;
   assign done_o      = done_q;
   assign status_o    = stat_q;

endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
   import rxdet_pkg::*;
#(
   parameter int unsigned LEAD_CYC = 10,
   parameter int unsigned TMO_CYC  = 4096,
   parameter bit          TMO_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       det_req_i,
   input  logic       fe_valid_i,
   input  logic       fe_found_i,
   output logic       elec_idle_o,
   output logic       det_ctrl_o,
   output logic       done_o,
   output logic [2:0] status_o
);
   if (LEAD_CYC < 10) begin : g_bad_lead
      $error("rxdet_seq: LEAD_CYC below the minimum idle lead of 10 cycles");
   end
   if (TMO_EN && TMO_CYC < 2) begin : g_bad_tmo
      $error("rxdet_seq: TMO_CYC must be at least 2");
   end

   rxdet_state_e state;
   logic         lead_hit;
   logic         tmo_hit;

   rxdet_span_cnt #(.LIMIT(LEAD_CYC)) u_lead (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (state == ST_FORCE),
      .hit_o (lead_hit)
   );

   if (TMO_EN) begin : g_tmo
      rxdet_span_cnt #(.LIMIT(TMO_CYC)) u_tmo (
         .clk   (clk),
         .rst_n (rst_n),
         .run_i (state == ST_DETECT),
         .hit_o (tmo_hit)
      );
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   rxdet_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .det_req_i   (det_req_i),
      .fe_valid_i  (fe_valid_i),
      .fe_found_i  (fe_found_i),
      .lead_hit_i  (lead_hit),
      .tmo_hit_i   (tmo_hit),
      .state_o     (state),
      .elec_idle_o (elec_idle_o),
      .det_ctrl_o  (det_ctrl_o),
      .done_o      (done_o),
      .status_o    (status_o)
   );

endmodule

// File: rtl/rxdet_seq_chk.sv
module rxdet_seq_chk #(
   parameter int unsigned LEAD_CYC = 10,
   parameter int unsigned TMO_CYC  = 4096,
   parameter bit          TMO_EN   = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       elec_idle_o,
   input logic       det_ctrl_o,
   input logic       done_o,
   input logic [2:0] status_o
);
   localparam int unsigned EW = $clog2(LEAD_CYC + 1);
   localparam int unsigned DW = $clog2(TMO_CYC + 1);

   logic [EW-1:0] eidle_run;
   logic [DW-1:0] det_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !elec_idle_o) eidle_run <= '0;
      else if (eidle_run != EW'(LEAD_CYC)) eidle_run <= eidle_run + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !det_ctrl_o) det_run <= '0;
      else if (det_run != DW'(TMO_CYC)) det_run <= det_run + 1'b1;
   end

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> status_o == 3'b000);

   // R4
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o == 3'b011 || status_o == 3'b000));

   // R2
   det_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_ctrl_o |-> elec_idle_o);

   // R2
   lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det_ctrl_o) |-> eidle_run >= EW'(LEAD_CYC));

   // R4
   det_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(det_ctrl_o) |-> done_o);

   // R9
   eidle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(elec_idle_o) |-> $past(done_o));

   if (TMO_EN) begin : g_tmo_chk
      // R8
      tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         det_ctrl_o |-> det_run < DW'(TMO_CYC));
   end

endmodule

bind rxdet_seq rxdet_seq_chk #(
   .LEAD_CYC (LEAD_CYC),
   .TMO_CYC  (TMO_CYC),
   .TMO_EN   (TMO_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .elec_idle_o (elec_idle_o),
   .det_ctrl_o  (det_ctrl_o),
   .done_o      (done_o),
   .status_o    (status_o)
);

// File: tb/rxdet_seq_bench.sv
`timescale 1ns/1ps
module rxdet_seq_bench;
   localparam int LEAD = 10;
   localparam int TMO  = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       det_req_i = 1'b0;
   logic       fe_valid_i = 1'b0;
   logic       fe_found_i = 1'b0;
   logic       elec_idle_o;
   logic       det_ctrl_o;
   logic       done_o;
   logic [2:0] status_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rxdet_seq #(.LEAD_CYC(LEAD), .TMO_CYC(TMO), .TMO_EN(1'b1)) u_rxdet_seq (
      .clk(clk), .rst_n(rst_n), .det_req_i(det_req_i),
      .fe_valid_i(fe_valid_i), .fe_found_i(fe_found_i),
      .elec_idle_o(elec_idle_o), .det_ctrl_o(det_ctrl_o),
      .done_o(done_o), .status_o(status_o));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 lead, 2 wait, 3 report, 4 release
   int         m_phase = 0;
   int         m_cnt = 0;
   logic       m_eidle = 1'b1;
   logic       m_det = 1'b0;
   logic       m_done = 1'b0;
   logic [2:0] m_stat = 3'b000;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase <= 0; m_cnt <= 0; m_eidle <= 1'b1; m_det <= 1'b0;
         m_done <= 1'b0; m_stat <= 3'b000;
      end else begin
         m_done <= 1'b0;
         m_stat <= 3'b000;
         if (m_phase == 0) begin
            if (det_req_i) begin m_phase <= 1; m_cnt <= 0; m_eidle <= 1'b1; end
         end else if (m_phase == 1) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt + 1 == LEAD) begin m_phase <= 2; m_cnt <= 0; m_det <= 1'b1; end
         end else if (m_phase == 2) begin
            m_cnt <= m_cnt + 1;
            if (fe_valid_i || (m_cnt + 1 == TMO)) begin
               m_phase <= 3; m_det <= 1'b0; m_done <= 1'b1;
               m_stat <= (fe_valid_i && fe_found_i) ? 3'b011 : 3'b000;
            end
         end else if (m_phase == 3) begin
            m_phase <= 4; m_eidle <= 1'b0;
         end else begin
            m_phase <= 0;
         end
      end
   end

   // Per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(elec_idle_o === m_eidle, "R9 elec_idle vs model", int'(elec_idle_o), int'(m_eidle));
         check(det_ctrl_o === m_det, "R3 det_ctrl vs model", int'(det_ctrl_o), int'(m_det));
         check(done_o === m_done, "R6 done vs model", int'(done_o), int'(m_done));
         check(status_o === m_stat, "R4 status vs model", int'(status_o), int'(m_stat));
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
         finish_run();
      end
   end

   // dly < 0 means no result: the watchdog must expire (R8).
   // start=0 continues a sequence already accepted; chain=1 holds a new request through done.
   task automatic run_seq(input int dly, input bit found, input bit poke,
                          input bit start, input bit chain);
      int lows = 0;
      int hi = 0;
      if (start) begin
         det_req_i = 1'b1;
         @(negedge clk);
         det_req_i = 1'b0;
      end
      while (!det_ctrl_o && lows < 100) begin
         lows++;
         det_req_i  = poke;
         fe_valid_i = poke;
         fe_found_i = poke;
         @(negedge clk);
      end
      det_req_i = 1'b0; fe_valid_i = 1'b0; fe_found_i = 1'b0;
      // R2 / R10: lead time exact even with stray valid pulses
      if (start) check(lows == LEAD, "R2 lead cycles before detect", lows, LEAD);
      else check(det_ctrl_o == 1'b1, "R7 chained sequence reached detect", int'(det_ctrl_o), 1);
      if (dly >= 0) begin
         repeat (dly) begin
            det_req_i = poke;
            @(negedge clk);
            hi++;
         end
         det_req_i = 1'b0;
         check(det_ctrl_o == 1'b1, "R3 detect held while waiting", int'(det_ctrl_o), 1);
         fe_valid_i = 1'b1; fe_found_i = found;
         @(negedge clk);
         fe_valid_i = 1'b0; fe_found_i = 1'b0;
         check(done_o == 1'b1, "R4 done after valid", int'(done_o), 1);
         if (found) check(status_o == 3'b011, "R4 status found", int'(status_o), 3);
         else check(status_o == 3'b000, "R5 status not found", int'(status_o), 0);
         check(det_ctrl_o == 1'b0, "R4 detect drops with done", int'(det_ctrl_o), 0);
      end else begin
         while (det_ctrl_o && hi < TMO + 5) begin
            hi++;
            @(negedge clk);
         end
         check(hi == TMO, "R8 detect high cycles before timeout", hi, TMO);
         check(done_o == 1'b1 && status_o == 3'b000, "R8 timeout report", int'(status_o), 0);
      end
      if (chain) det_req_i = 1'b1;
      @(negedge clk);
      check(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
      check(elec_idle_o == 1'b0, "R9 idle released after done", int'(elec_idle_o), 0);
      @(negedge clk);
      if (chain) begin
         check(elec_idle_o == 1'b0, "R7 request not yet accepted", int'(elec_idle_o), 0);
         @(negedge clk);
         det_req_i = 1'b0;
         check(elec_idle_o == 1'b1, "R7 request accepted third edge", int'(elec_idle_o), 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(elec_idle_o == 1'b1, "R1 reset elec_idle", int'(elec_idle_o), 1);
      check(det_ctrl_o == 1'b0, "R1 reset det_ctrl", int'(det_ctrl_o), 0);
      check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
      check(status_o == 3'b000, "R1 reset status", int'(status_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_seq(0, 1'b1, 1'b0, 1'b1, 1'b0);
      run_seq(5, 1'b0, 1'b0, 1'b1, 1'b0);
      // R7 / R10: requests and stray valid pulses during a running sequence
      run_seq(37, 1'b1, 1'b1, 1'b1, 1'b0);

      // R10: valid in idle does nothing
      repeat (6) begin
         fe_valid_i = 1'b1; fe_found_i = 1'b1;
         @(negedge clk);
         check(done_o == 1'b0, "R10 valid ignored in idle", int'(done_o), 0);
         check(elec_idle_o == 1'b0, "R10 idle stays released", int'(elec_idle_o), 0);
      end
      fe_valid_i = 1'b0; fe_found_i = 1'b0;
      @(negedge clk);

      // R7: back-to-back requests
      run_seq(2, 1'b1, 1'b0, 1'b1, 1'b1);
      run_seq(1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R8 boundary: result on the last wait cycle wins
      run_seq(TMO - 1, 1'b1, 1'b0, 1'b1, 1'b0);
      // R8: no result at all
      run_seq(-1, 1'b0, 1'b0, 1'b1, 1'b0);
      run_seq(3, 1'b1, 1'b0, 1'b1, 1'b0);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule